// File: doc/BRIEF.md
# Satellite Host Interface Controller

This block sits between a synchronous processor bus and an array of dataflow satellites (address generators, I/O ports, arithmetic and memory units). The configuration storage of every satellite appears in the processor's address space. Each processor access is turned into a configuration read or write, with a one-hot region select, a write or read qualifier, and the configuration address and data buses. The block also holds a small control space. From it the processor starts kernels on the address generators and I/O ports, pulses a network reset, and manages end-of-kernel events.

Each start target reports completion on an acknowledge line. A rising acknowledge latches a sticky pending bit. Pending bits pass through a mask to drive one interrupt line. In test mode the processor bus is disconnected and a set of test pins drives the same access path. Satellites can then be configured, kernels started and results read back from outside the chip, with the interrupt pin marking end of kernel.

Top module: `sat_host_ctrl`

## Requirements
- R1: A write to the configuration window (address bit 16 = 1) whose region field (address bits 15:12) is below 9 raises strobe bit `region` and strobe bit 9 (write) for exactly the following cycle, with `cfg_addr` equal to address bits 15:0 and `cfg_wdata` equal to the write data.
- R2: A read of a mapped configuration address raises strobe bit `region` and strobe bit 10 (read) in the following cycle. The `cfg_rdata` value of that cycle appears on `bus_rdata` and `tst_data_out` one cycle later.
- R3: A configuration access with region field 9 to 15, or a control access with offset 4 or above, produces no strobe, and a read from such an address returns zero.
- R4: A write to control offset 2 raises strobe bit 12+i for exactly one cycle for each set bit i of data bits 9:0. Reads of offset 2 return zero.
- R5: A write to control offset 3 with data bit 0 set holds strobe bit 11 (network reset) high for exactly 4 consecutive cycles. Reads of offset 3 return the reset-active state in bit 0.
- R6: A rising edge on `ack[i]` sets pending bit i. A level that stays high does not set the bit again after it has been cleared.
- R7: Writing control offset 0 clears each pending bit whose data bit is 1 and leaves the others unchanged. Reads of offset 0 return the pending bits in bits 9:0.
- R8: `irq` is high exactly when some pending bit and its mask bit are both set. The mask is written and read at control offset 1, bits 9:0.
- R9: While `test_mode` is high, processor bus requests are ignored. `tst_en` issues accesses instead, with `tst_ctl` = 1 selecting the control space and 0 the configuration window.
- R10: After reset all strobes, `irq`, the pending bits, the mask and the read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | Selects the test pins as the access source |
| bus_sel | input | 1 | Processor access request |
| bus_wr | input | 1 | Processor access is a write |
| bus_addr | input | 17 | Bit 16 = configuration window, bits 15:0 offset |
| bus_wdata | input | 32 | Processor write data |
| bus_rdata | output | 32 | Read result, two cycles after the request |
| tst_en | input | 1 | Test access request |
| tst_wr | input | 1 | Test access is a write |
| tst_ctl | input | 1 | Test access targets the control space |
| tst_addr | input | 16 | Test address |
| tst_wdata | input | 32 | Test write data |
| tst_data_out | output | 32 | Read result seen on the test pins |
| cfg_addr | output | 16 | Configuration address bus |
| cfg_wdata | output | 32 | Configuration data bus |
| cfg_rdata | input | 32 | Read data from the selected satellite |
| strobe | output | 22 | 8:0 region select, 9 write, 10 read, 11 network reset, 21:12 start |
| ack | input | 10 | End-of-kernel acknowledges |
| irq | output | 1 | Masked end-of-kernel interrupt |

## Verification
On every cycle the assertions check several invariants. At most one region strobe is active, and write and read are never strobed together. A network reset, once raised, stays up into the next cycle. A rising acknowledge is always followed by its pending bit. A zero mask keeps the interrupt low, unmapped reads return zero, and an idle test port in test mode issues nothing. Other properties can only be shown by the bench's scenarios: the exact pulse lengths, the write-one-clear behaviour with the acknowledge still high, the data path from the satellites back to both read outputs, and the isolation of the processor bus in test mode.

// File: rtl/sat_host_pkg.sv
package sat_host_pkg;

    localparam int CADDR_W    = 16;
    localparam int CDATA_W    = 32;
    localparam int NUM_ACK    = 10;
    localparam int NUM_REGION = 9;
    localparam int REGION_LSB = 12;
    localparam int REGION_W   = CADDR_W - REGION_LSB;
    localparam int STRB_WE    = NUM_REGION;
    localparam int STRB_RE    = NUM_REGION + 1;
    localparam int STRB_NRST  = NUM_REGION + 2;
    localparam int STRB_START = NUM_REGION + 3;
    localparam int STRB_W     = STRB_START + NUM_ACK;

    typedef enum logic [1:0] {
        CR_PEND  = 2'd0,
        CR_MASK  = 2'd1,
        CR_START = 2'd2,
        CR_NRST  = 2'd3
    } ctrl_reg_e;

    typedef struct packed {
        logic               valid;
        logic               wr;
        logic               win;
        logic [CADDR_W-1:0] addr;
        logic [CDATA_W-1:0] wdata;
    } access_t;

    function automatic logic region_ok(input logic [CADDR_W-1:0] a);
        return int'(a[REGION_LSB +: REGION_W]) < NUM_REGION;
    endfunction

    function automatic logic ctrl_ok(input logic [CADDR_W-1:0] a);
        return a[CADDR_W-1:2] == '0;
    endfunction

    function automatic ctrl_reg_e ctrl_sel(input logic [CADDR_W-1:0] a);
        return ctrl_reg_e'(a[1:0]);
    endfunction

endpackage

// File: rtl/sat_access_stage.sv
module sat_access_stage
    import sat_host_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               test_mode,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [CADDR_W:0]   bus_addr,
    input  logic [CDATA_W-1:0] bus_wdata,
    input  logic               tst_en,
    input  logic               tst_wr,
    input  logic               tst_ctl,
    input  logic [CADDR_W-1:0] tst_addr,
    input  logic [CDATA_W-1:0] tst_wdata,
    output access_t            acc_q
);

    access_t req;

    always_comb begin
        if (test_mode) begin
            req.valid = tst_en;
            req.wr    = tst_wr;
            req.win   = ~tst_ctl;
            req.addr  = tst_addr;
            req.wdata = tst_wdata;
        end else begin
            req.valid = bus_sel;
            req.wr    = bus_wr;
            req.win   = bus_addr[CADDR_W];
            req.addr  = bus_addr[CADDR_W-1:0];
            req.wdata = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= req;
    end

    AST_TEST_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (test_mode && !tst_en) |=> !acc_q.valid); // R9

endmodule

// File: rtl/sat_strobe_gen.sv
module sat_strobe_gen
    import sat_host_pkg::*;
#(
    parameter int NRST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    output logic [STRB_W-1:0] strobe,
    output logic              nrst_busy
);

    localparam int CNT_W = $clog2(NRST_CYC + 1);

    logic             cfg_hit;
    logic             ctrl_wr;
    logic             nrst_load;
    logic [CNT_W-1:0] nrst_cnt;

    assign cfg_hit   = acc.valid && acc.win && region_ok(acc.addr);
    assign ctrl_wr   = acc.valid && acc.wr && !acc.win && ctrl_ok(acc.addr);
    assign nrst_load = ctrl_wr && (ctrl_sel(acc.addr) == CR_NRST) && acc.wdata[0];

    generate
        for (genvar g = 0; g < NUM_REGION; g++) begin : g_region
            assign strobe[g] = cfg_hit &&
                (int'(acc.addr[REGION_LSB +: REGION_W]) == g);
        end
        for (genvar s = 0; s < NUM_ACK; s++) begin : g_start
            assign strobe[STRB_START + s] = ctrl_wr &&
                (ctrl_sel(acc.addr) == CR_START) && acc.wdata[s];
        end
    endgenerate

    assign strobe[STRB_WE]   = cfg_hit && acc.wr;
    assign strobe[STRB_RE]   = cfg_hit && !acc.wr;
    assign nrst_busy         = nrst_load || (nrst_cnt != '0);
    assign strobe[STRB_NRST] = nrst_busy;

    always_ff @(posedge clk) begin
        if (rst)                  nrst_cnt <= '0;
        else if (nrst_load)       nrst_cnt <= CNT_W'(NRST_CYC - 1);
        else if (nrst_cnt != '0)  nrst_cnt <= nrst_cnt - 1'b1;
    end

    AST_ONE_REGION: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe[NUM_REGION-1:0])); // R1
    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(strobe[STRB_WE] && strobe[STRB_RE])); // R2
    AST_NRST_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe[STRB_NRST]) |=> strobe[STRB_NRST]); // R5

endmodule

// File: rtl/sat_event_unit.sv
module sat_event_unit
    import sat_host_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_ACK-1:0] ack,
    input  logic               clr_we,
    input  logic [NUM_ACK-1:0] clr_bits,
    input  logic               mask_we,
    input  logic [NUM_ACK-1:0] mask_d,
    output logic [NUM_ACK-1:0] pend,
    output logic [NUM_ACK-1:0] mask,
    output logic               irq
);

    logic [NUM_ACK-1:0] ack_q;
    logic [NUM_ACK-1:0] rise;
    logic [NUM_ACK-1:0] clr;

    assign rise = ack & ~ack_q;
    assign clr  = clr_we ? clr_bits : '0;
    assign irq  = |(pend & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= '0;
            pend  <= '0;
            mask  <= '0;
        end else begin
            ack_q <= ack;
            pend  <= (pend & ~clr) | rise;
            if (mask_we) mask <= mask_d;
        end
    end

    generate
        for (genvar i = 0; i < NUM_ACK; i++) begin : g_chk
            AST_PEND_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
                $rose(ack[i]) |=> pend[i]); // R6
        end
    endgenerate

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq); // R8

endmodule

// File: rtl/sat_host_ctrl.sv
module sat_host_ctrl
    import sat_host_pkg::*;
#(
    parameter int NRST_CYC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               test_mode,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [CADDR_W:0]   bus_addr,
    input  logic [CDATA_W-1:0] bus_wdata,
    output logic [CDATA_W-1:0] bus_rdata,
    input  logic               tst_en,
    input  logic               tst_wr,
    input  logic               tst_ctl,
    input  logic [CADDR_W-1:0] tst_addr,
    input  logic [CDATA_W-1:0] tst_wdata,
    output logic [CDATA_W-1:0] tst_data_out,
    output logic [CADDR_W-1:0] cfg_addr,
    output logic [CDATA_W-1:0] cfg_wdata,
    input  logic [CDATA_W-1:0] cfg_rdata,
    output logic [STRB_W-1:0]  strobe,
    input  logic [NUM_ACK-1:0] ack,
    output logic               irq
);

    access_t            acc;
    logic               nrst_busy;
    logic [NUM_ACK-1:0] pend;
    logic [NUM_ACK-1:0] mask;
    logic               ctrl_wr;
    logic               mapped;
    logic [CDATA_W-1:0] rd_val;
    logic [CDATA_W-1:0] rdata_q;

    sat_access_stage u_acc (
        .clk       (clk),
        .rst       (rst),
        .test_mode (test_mode),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .tst_en    (tst_en),
        .tst_wr    (tst_wr),
        .tst_ctl   (tst_ctl),
        .tst_addr  (tst_addr),
        .tst_wdata (tst_wdata),
        .acc_q     (acc)
    );

    sat_strobe_gen #(.NRST_CYC(NRST_CYC)) u_strb (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .strobe    (strobe),
        .nrst_busy (nrst_busy)
    );

    assign ctrl_wr = acc.valid && acc.wr && !acc.win && ctrl_ok(acc.addr);

    sat_event_unit u_evt (
        .clk      (clk),
        .rst      (rst),
        .ack      (ack),
        .clr_we   (ctrl_wr && ctrl_sel(acc.addr) == CR_PEND),
        .clr_bits (acc.wdata[NUM_ACK-1:0]),
        .mask_we  (ctrl_wr && ctrl_sel(acc.addr) == CR_MASK),
        .mask_d   (acc.wdata[NUM_ACK-1:0]),
        .pend     (pend),
        .mask     (mask),
        .irq      (irq)
    );

    assign cfg_addr  = acc.addr;
    assign cfg_wdata = acc.wdata;
    assign mapped    = acc.win ? region_ok(acc.addr) : ctrl_ok(acc.addr);

    always_comb begin
        rd_val = '0;
        if (mapped) begin
            if (acc.win) begin
                rd_val = cfg_rdata;
            end else begin
                unique case (ctrl_sel(acc.addr))
                    CR_PEND:  rd_val = CDATA_W'(pend);
                    CR_MASK:  rd_val = CDATA_W'(mask);
                    CR_START: rd_val = '0;
                    CR_NRST:  rd_val = CDATA_W'(nrst_busy);
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                         rdata_q <= '0;
        else if (acc.valid && !acc.wr)   rdata_q <= rd_val;
    end

    assign bus_rdata    = rdata_q;
    assign tst_data_out = rdata_q;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc.valid && !acc.wr && !mapped) |=> (bus_rdata == '0)); // R3

endmodule

// File: tb/sim_sat_host_ctrl.sv
module sim_sat_host_ctrl;
    import sat_host_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, test_mode, bus_sel, bus_wr, tst_en, tst_wr, tst_ctl, irq;
    logic [16:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata, tst_wdata, tst_data_out, cfg_wdata, cfg_rdata;
    logic [15:0] tst_addr, cfg_addr;
    logic [21:0] strobe;
    logic [9:0]  ack;

    assign cfg_rdata = {cfg_addr, ~cfg_addr};

    sat_host_ctrl u0 (.*);

    int checks = 0, failures = 0;
    bit finished = 1'b0;
    logic [21:0] got_strb;
    logic [15:0] got_caddr;
    logic [31:0] got_cwd, got_rd;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [21:0] exp_strb(input bit wr, input bit win, input logic [15:0] a, input logic [31:0] d);
        logic [21:0] s = '0;
        if (win) begin
            if (a[15:12] < 9) begin
                s[a[15:12]] = 1'b1;
                s[9]  = wr;
                s[10] = !wr;
            end
        end else if (wr && a == 16'd2) begin
            s[21:12] = d[9:0];
        end else if (wr && a == 16'd3 && d[0]) begin
            s[11] = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [31:0] exp_cfg_rd(input logic [15:0] a);
        return (a[15:12] < 9) ? {a, ~a} : 32'h0;
    endfunction

    task automatic access(input bit tst, input bit wr, input bit win, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        if (tst) begin
            tst_en = 1; tst_wr = wr; tst_ctl = !win; tst_addr = a; tst_wdata = d;
        end else begin
            bus_sel = 1; bus_wr = wr; bus_addr = {win, a}; bus_wdata = d;
        end
        @(negedge clk);
        bus_sel = 0; tst_en = 0;
        got_strb = strobe; got_caddr = cfg_addr; got_cwd = cfg_wdata;
        @(negedge clk);
        got_rd = tst ? tst_data_out : bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        rst = 1; test_mode = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        tst_en = 0; tst_wr = 0; tst_ctl = 0; tst_addr = '0; tst_wdata = '0; ack = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        // R10 reset state
        chk(strobe == '0, "R10 strobe", 32'(strobe), 0);
        chk(irq == 0, "R10 irq", 32'(irq), 0);
        chk(bus_rdata == '0, "R10 rdata", bus_rdata, 0);
        access(0, 0, 0, 16'd0, 0);
        chk(got_rd == 0, "R10 pending", got_rd, 0);
        access(0, 0, 0, 16'd1, 0);
        chk(got_rd == 0, "R10 mask", got_rd, 0);

        // R1 / R2 directed
        access(0, 1, 1, 16'h8ABC, 32'hDEADBEEF);
        chk(got_strb == exp_strb(1, 1, 16'h8ABC, 0), "R1 strobe", 32'(got_strb), 32'(exp_strb(1, 1, 16'h8ABC, 0)));
        chk(got_caddr == 16'h8ABC, "R1 cfg_addr", 32'(got_caddr), 32'h8ABC);
        chk(got_cwd == 32'hDEADBEEF, "R1 cfg_wdata", got_cwd, 32'hDEADBEEF);
        chk(strobe == '0, "R1 single cycle", 32'(strobe), 0);
        access(0, 0, 1, 16'h0123, 0);
        chk(got_strb == exp_strb(0, 1, 16'h0123, 0), "R2 strobe", 32'(got_strb), 32'(exp_strb(0, 1, 16'h0123, 0)));
        chk(got_rd == exp_cfg_rd(16'h0123), "R2 rdata", got_rd, exp_cfg_rd(16'h0123));

        // R3 unmapped
        access(0, 0, 1, 16'h9000, 0);
        chk(got_strb == '0, "R3 strobe region9", 32'(got_strb), 0);
        chk(got_rd == 0, "R3 rdata region9", got_rd, 0);
        access(0, 0, 0, 16'h0007, 0);
        chk(got_rd == 0, "R3 rdata ctrl", got_rd, 0);
        access(0, 1, 0, 16'h0041, 32'h3FF);
        chk(got_strb == '0, "R3 ctrl write strobe", 32'(got_strb), 0);
        access(0, 0, 0, 16'd1, 0);
        chk(got_rd == 0, "R3 mask unchanged", got_rd, 0);

        // Random configuration accesses, R1 R2 R3
        for (int i = 0; i < 60; i++) begin
            bit wr = 1'($urandom);
            logic [15:0] a = 16'($urandom);
            logic [31:0] d = $urandom;
            access(0, wr, 1, a, d);
            chk(got_strb == exp_strb(wr, 1, a, d), "R1 R2 R3 random strobe", 32'(got_strb), 32'(exp_strb(wr, 1, a, d)));
            if (exp_strb(wr, 1, a, d) != '0)
                chk(got_caddr == a, "R1 random cfg_addr", 32'(got_caddr), 32'(a));
            if (!wr) chk(got_rd == exp_cfg_rd(a), "R2 R3 random rdata", got_rd, exp_cfg_rd(a));
        end

        // R4 start pulses
        access(0, 1, 0, 16'd2, 32'hFFFF_F205);
        chk(got_strb == exp_strb(1, 0, 16'd2, 32'h205), "R4 start", 32'(got_strb), 32'(exp_strb(1, 0, 16'd2, 32'h205)));
        chk(strobe == '0, "R4 one cycle", 32'(strobe), 0);
        access(0, 0, 0, 16'd2, 0);
        chk(got_rd == 0, "R4 read zero", got_rd, 0);

        // R5 network reset length
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = {1'b0, 16'd3}; bus_wdata = 32'h1;
        n = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            bus_sel = 0;
            if (strobe[11]) n++;
        end
        chk(n == 4, "R5 length", 32'(n), 4);
        access(0, 1, 0, 16'd3, 32'h1);
        access(0, 0, 0, 16'd3, 0);
        chk(got_rd == 1, "R5 busy", got_rd, 1);
        repeat (8) @(negedge clk);
        access(0, 0, 0, 16'd3, 0);
        chk(got_rd == 0, "R5 idle", got_rd, 0);

        // R6 R7 R8 events
        @(negedge clk); ack[3] = 1;
        repeat (2) @(negedge clk);
        access(0, 0, 0, 16'd0, 0);
        chk(got_rd == 32'h8, "R6 pending set", got_rd, 32'h8);
        chk(irq == 0, "R8 masked", 32'(irq), 0);
        access(0, 1, 0, 16'd1, 32'h8);
        chk(irq == 1, "R8 irq", 32'(irq), 1);
        access(0, 0, 0, 16'd1, 0);
        chk(got_rd == 32'h8, "R8 mask read", got_rd, 32'h8);
        access(0, 1, 0, 16'd0, 32'h0);
        access(0, 0, 0, 16'd0, 0);
        chk(got_rd == 32'h8, "R7 zero write keeps", got_rd, 32'h8);
        access(0, 1, 0, 16'd0, 32'h8);
        access(0, 0, 0, 16'd0, 0);
        chk(got_rd == 0, "R6 R7 cleared with ack high", got_rd, 0);
        chk(irq == 0, "R8 irq cleared", 32'(irq), 0);
        @(negedge clk); ack[3] = 0; ack[7] = 1;
        @(negedge clk); ack[3] = 1;
        repeat (2) @(negedge clk);
        access(0, 0, 0, 16'd0, 0);
        chk(got_rd == 32'h88, "R6 re-edge", got_rd, 32'h88);
        chk(irq == 1, "R8 irq again", 32'(irq), 1);

        // R9 test mode
        @(negedge clk); test_mode = 1;
        access(0, 1, 1, 16'h2000, 32'h1234);
        chk(got_strb == '0, "R9 bus ignored", 32'(got_strb), 0);
        access(1, 1, 1, 16'h4321, 32'hCAFE0001);
        chk(got_strb == exp_strb(1, 1, 16'h4321, 0), "R9 test write", 32'(got_strb), 32'(exp_strb(1, 1, 16'h4321, 0)));
        chk(got_cwd == 32'hCAFE0001, "R9 test data", got_cwd, 32'hCAFE0001);
        access(1, 0, 1, 16'h5555, 0);
        chk(got_rd == exp_cfg_rd(16'h5555), "R9 test read", got_rd, exp_cfg_rd(16'h5555));
        access(1, 0, 0, 16'd0, 0);
        chk(got_rd == 32'h88, "R9 test ctrl read", got_rd, 32'h88);
        chk(bus_rdata == 32'h88, "R9 shared rdata", bus_rdata, 32'h88);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule